// File: doc/BRIEF.md
# DDS Host Load and Transfer Controller

This block is the host side of a direct digital synthesiser. A processor builds 32-bit words in one of two staging registers. The first is a parallel staging word, filled from an 8- or 16-bit bus by write strobes. The second is a serial staging word, filled one bit per serial clock. A 4-bit transfer code, qualified by a load strobe, then copies one staging word into one working register. The working registers are the control word, two frequency steps, a phase offset and an I/Q amplitude word.

The write strobe and the serial clock are independent of the DDS clock. The load strobe, the transfer code and the frequency-select input reach the DDS clock domain through a four-stage pipeline, and a control bit can bypass that pipeline. A transfer fires on the rising edge of the load strobe as seen in the DDS clock domain. One pulse therefore performs exactly one copy.

Top module: `dds_load_ctrl`

## Requirements
- R1: On each falling edge of `wr_n` with `cs_n` low, in 16-bit mode (control bit 0 = 1) the parallel staging word shifts left by 16 and `data_in[15:0]` enters the low half, so two writes, most significant half first, fill it.
- R2: In 8-bit mode (control bit 0 = 0) each write shifts the parallel staging word left by 8 and takes only `data_in[7:0]`; `data_in[15:8]` has no effect, and four writes, most significant byte first, fill the word.
- R3: On each rising edge of `sclk` the serial staging word shifts left by one and `sdata` enters bit 0, so 32 clocks load a word most significant bit first.
- R4: On a load rising edge the transfer code selects source and destination: 00xx copies parallel into the control word; 1000, 1001, 1010, 1011 copy parallel into frequency 0, frequency 1, phase and I/Q; 1100 to 1111 copy serial into the same four; 01xx changes nothing.
- R5: The phase offset takes the low 12 bits of the source, the I/Q word the low 20 bits, and each frequency step all 32 bits.
- R6: Control bits: bit 0 bus width (1 = 16-bit), bit 1 sleep, bit 2 amplitude-modulation enable, bit 3 synchroniser bypass; `sleep_out` is control bit 1 ORed with `sleep_in`.
- R7: One load pulse performs one transfer: while `load` stays high, later changes of the staging word do not reach the destination.
- R8: With bypass off, `load`, `tc` and `fsel_in` pass four DDS clock stages before use, so `fsel_out` follows 4 clocks late and a transfer lands 4 clocks later than with bypass on; with bypass on, `fsel_out` follows `fsel_in` at once and a load set up before a clock edge lands at that edge.
- R9: Reset clears every working register and the control word: 8-bit bus, awake, amplitude modulation off, synchroniser in use.
- R10: A write strobe with `cs_n` high leaves the parallel staging word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DDS clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Parallel write strobe, data taken on falling edge |
| cs_n | input | 1 | Parallel chip select, active low |
| data_in | input | 16 | Parallel data bus |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data, MSB first |
| load | input | 1 | Transfer strobe |
| tc | input | 4 | Transfer code |
| fsel_in | input | 1 | Frequency register select |
| sleep_in | input | 1 | External sleep request |
| fsel_out | output | 1 | Frequency select in the DDS clock domain |
| freq0 | output | 32 | Frequency step 0 |
| freq1 | output | 32 | Frequency step 1 |
| phase_ofs | output | 12 | Phase offset |
| iq_amp | output | 20 | I/Q amplitude word |
| bus16 | output | 1 | Control bit 0, 16-bit bus |
| sleep_out | output | 1 | Sleep request, control bit 1 or sleep_in |
| am_en | output | 1 | Control bit 2, amplitude modulation |
| sync_off | output | 1 | Control bit 3, synchroniser bypass |

## Verification
The hardest case to reach from the ports is the exact cycle in which a transfer lands in each synchroniser mode. The pipeline is invisible except through the latency it adds. The bench raises `load` and `fsel_in` on a known falling clock edge and samples the outputs on each following falling edge. It does this once with the pipeline bypassed and once with it in use, and checks that the landing cycle moves by four. A second case needs a staging word that changes while `load` is still high. The bench holds the strobe and writes new data through the parallel bus, then checks that the destination kept the first value. The directed cases are mixed with seeded random word, bus-width and transfer-code sequences.

// File: rtl/dds_ctl_pkg.sv
package dds_ctl_pkg;
  localparam int unsigned CMD_W = 4;
  localparam int unsigned TC_W  = 4;

  // control word, bit 0 at the right
  typedef struct packed {
    logic sync_off;  // bit 3
    logic am_en;     // bit 2
    logic sleep;     // bit 1
    logic bus16;     // bit 0
  } ctl_word_t;
endpackage

// File: rtl/dds_par_asm.sv
module dds_par_asm #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BUS_W  = 16
) (
  input  logic              wr_n,
  input  logic              cs_n,
  input  logic              rst_n,
  input  logic              bus16,
  input  logic [BUS_W-1:0]  din,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned HALF_W = BUS_W / 2;

  logic [WORD_W-1:0] word_nxt;

  always_comb begin
    if (bus16) word_nxt = {word[WORD_W-BUS_W-1:0], din};
    else       word_nxt = {word[WORD_W-HALF_W-1:0], din[HALF_W-1:0]};
  end

  always_ff @(negedge wr_n or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (!cs_n) word <= word_nxt;
  end

  // R2: narrow mode moves the old low part up by one byte
  a_r2_byte_shift: assert property (@(negedge wr_n) disable iff (!rst_n)
    (!cs_n && !bus16) |=> word[WORD_W-1:HALF_W] == $past(word[WORD_W-HALF_W-1:0]));
endmodule

// File: rtl/dds_ser_asm.sv
module dds_ser_asm #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              sdata,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] word_nxt;

  always_comb word_nxt = {word[WORD_W-2:0], sdata};

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else        word <= word_nxt;
  end

  // R3: one place per serial clock, MSB leaves first
  a_r3_ser_shift: assert property (@(posedge sclk) disable iff (!rst_n)
    1'b1 |=> word[WORD_W-1:1] == $past(word[WORD_W-2:0]));
endmodule

// File: rtl/dds_ctl_sync.sv
module dds_ctl_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bypass,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg     [STAGES];
  logic [W-1:0] stg_nxt [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_comb stg_nxt[i] = d;
    end else begin : g_rest
      always_comb stg_nxt[i] = stg[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg_nxt[i];
    end
  end

  assign q = bypass ? d : stg[STAGES-1];
endmodule

// File: rtl/dds_load_ctrl.sv
module dds_load_ctrl
  import dds_ctl_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned BUS_W       = 16,
  parameter int unsigned PH_W        = 12,
  parameter int unsigned IQ_W        = 20,
  parameter int unsigned SYNC_STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              cs_n,
  input  logic [BUS_W-1:0]  data_in,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              load,
  input  logic [TC_W-1:0]   tc,
  input  logic              fsel_in,
  input  logic              sleep_in,
  output logic              fsel_out,
  output logic [WORD_W-1:0] freq0,
  output logic [WORD_W-1:0] freq1,
  output logic [PH_W-1:0]   phase_ofs,
  output logic [IQ_W-1:0]   iq_amp,
  output logic              bus16,
  output logic              sleep_out,
  output logic              am_en,
  output logic              sync_off
);
  localparam int unsigned CTL_IN_W = TC_W + 2;

  // reset: asserted at once, released on a clock edge
  logic rst_meta, rst_clk_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_clk_n, rst_meta} <= 2'b00;
    else        {rst_clk_n, rst_meta} <= {rst_meta, 1'b1};
  end

  ctl_word_t ctl_q;
  logic [WORD_W-1:0] par_word, ser_word, src;

  dds_par_asm #(.WORD_W(WORD_W), .BUS_W(BUS_W)) i_par (
    .wr_n(wr_n), .cs_n(cs_n), .rst_n(rst_n), .bus16(ctl_q.bus16),
    .din(data_in), .word(par_word));

  dds_ser_asm #(.WORD_W(WORD_W)) i_ser (
    .sclk(sclk), .rst_n(rst_n), .sdata(sdata), .word(ser_word));

  logic [CTL_IN_W-1:0] ctl_raw, ctl_sel;
  assign ctl_raw = {fsel_in, load, tc};

  dds_ctl_sync #(.W(CTL_IN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_clk_n), .bypass(ctl_q.sync_off),
    .d(ctl_raw), .q(ctl_sel));

  logic            load_s, load_prev, load_rise;
  logic [TC_W-1:0] tc_s;
  assign fsel_out = ctl_sel[CTL_IN_W-1];
  assign load_s   = ctl_sel[TC_W];
  assign tc_s     = ctl_sel[TC_W-1:0];

  always_ff @(posedge clk or negedge rst_clk_n) begin
    if (!rst_clk_n) load_prev <= 1'b0;
    else            load_prev <= load_s;
  end
  assign load_rise = load_s & ~load_prev;

  // transfer decode
  logic we_ctl, we_f0, we_f1, we_ph, we_iq, we_any;
  always_comb begin
    we_ctl = load_rise & (tc_s[3:2] == 2'b00);
    we_f0  = load_rise & tc_s[3] & (tc_s[1:0] == 2'd0);
    we_f1  = load_rise & tc_s[3] & (tc_s[1:0] == 2'd1);
    we_ph  = load_rise & tc_s[3] & (tc_s[1:0] == 2'd2);
    we_iq  = load_rise & tc_s[3] & (tc_s[1:0] == 2'd3);
    we_any = we_ctl | we_f0 | we_f1 | we_ph | we_iq;
    src    = tc_s[2] ? ser_word : par_word;
  end

  always_ff @(posedge clk or negedge rst_clk_n) begin
    if (!rst_clk_n) begin
      ctl_q     <= '0;
      freq0     <= '0;
      freq1     <= '0;
      phase_ofs <= '0;
      iq_amp    <= '0;
    end else begin
      if (we_ctl) ctl_q     <= ctl_word_t'(par_word[CMD_W-1:0]);
      if (we_f0)  freq0     <= src;
      if (we_f1)  freq1     <= src;
      if (we_ph)  phase_ofs <= src[PH_W-1:0];
      if (we_iq)  iq_amp    <= src[IQ_W-1:0];
    end
  end

  assign bus16     = ctl_q.bus16;
  assign sleep_out = ctl_q.sleep | sleep_in;
  assign am_en     = ctl_q.am_en;
  assign sync_off  = ctl_q.sync_off;

  // R4: at most one destination per transfer
  a_r4_one_dest: assert property (@(posedge clk) disable iff (!rst_clk_n)
    $onehot0({we_ctl, we_f0, we_f1, we_ph, we_iq}));
  // R7: a load edge yields a single write cycle
  a_r7_single_shot: assert property (@(posedge clk) disable iff (!rst_clk_n)
    we_any |=> !we_any);
  // R6: control word moves only on its own transfer
  a_r6_ctl_hold: assert property (@(posedge clk) disable iff (!rst_clk_n)
    !we_ctl |=> $stable(ctl_q));
  // R5: phase offset moves only on its own transfer
  a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_clk_n)
    !we_ph |=> $stable(phase_ofs));
endmodule

// File: tb/test_dds_load_ctrl.sv
module test_dds_load_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, wr_n, cs_n, sclk, sdata, load, fsel_in, sleep_in;
  logic [15:0] data_in;
  logic [3:0]  tc;
  logic        fsel_out, bus16, sleep_out, am_en, sync_off;
  logic [31:0] freq0, freq1;
  logic [11:0] phase_ofs;
  logic [19:0] iq_amp;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_par, m_ser, m_f0, m_f1;
  logic [11:0] m_ph;
  logic [19:0] m_iq;
  logic [3:0]  m_ctl;

  always #2 clk = ~clk;

  dds_load_ctrl i_dds_load_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs_n(cs_n), .data_in(data_in),
    .sclk(sclk), .sdata(sdata), .load(load), .tc(tc), .fsel_in(fsel_in),
    .sleep_in(sleep_in), .fsel_out(fsel_out), .freq0(freq0), .freq1(freq1),
    .phase_ofs(phase_ofs), .iq_amp(iq_amp), .bus16(bus16),
    .sleep_out(sleep_out), .am_en(am_en), .sync_off(sync_off));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " freq0"}, freq0, m_f0);
    chk({req, " freq1"}, freq1, m_f1);
    chk({req, " phase"}, {20'd0, phase_ofs}, {20'd0, m_ph});
    chk({req, " iq"}, {12'd0, iq_amp}, {12'd0, m_iq});
    chk({req, " ctl"}, {28'd0, sync_off, am_en, sleep_out, bus16},
        {28'd0, m_ctl[3], m_ctl[2], m_ctl[1] | sleep_in, m_ctl[0]});
  endtask

  function automatic logic [31:0] par_shift(logic [31:0] w, logic [15:0] d, logic wide);
    return wide ? {w[15:0], d} : {w[23:0], d[7:0]};
  endfunction

  task automatic par_wr(input logic [15:0] d, input logic sel);
    cs_n = ~sel; data_in = d;
    #3 wr_n = 1'b0;
    #3 wr_n = 1'b1;
    #1 cs_n = 1'b1;
    if (sel) m_par = par_shift(m_par, d, m_ctl[0]);
  endtask

  // R1 / R2: whole word, most significant part first
  task automatic par_word(input logic [31:0] v);
    if (m_ctl[0]) begin
      par_wr(v[31:16], 1'b1);
      par_wr(v[15:0], 1'b1);
    end else begin
      for (int b = 3; b >= 0; b--) par_wr({8'($urandom), v[b*8 +: 8]}, 1'b1);
    end
  endtask

  task automatic ser_word(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) begin
      sdata = v[i];
      #2 sclk = 1'b1;
      #2 sclk = 1'b0;
    end
    m_ser = v;
  endtask

  task automatic model_xfer(input logic [3:0] code);
    logic [31:0] s;
    s = code[2] ? m_ser : m_par;
    if (code[3:2] == 2'b00) m_ctl = m_par[3:0];
    else if (code[3]) begin
      case (code[1:0])
        2'd0: m_f0 = s;
        2'd1: m_f1 = s;
        2'd2: m_ph = s[11:0];
        default: m_iq = s[19:0];
      endcase
    end
  endtask

  task automatic xfer(input logic [3:0] code);
    @(negedge clk);
    tc = code; load = 1'b1;
    repeat (6) @(negedge clk);
    load = 1'b0;
    repeat (6) @(negedge clk);
    model_xfer(code);
  endtask

  task automatic set_ctl(input logic [3:0] c);
    par_word({28'd0, c});
    xfer(4'b0000);
  endtask

  initial begin
    logic [31:0] v, old;
    logic [3:0]  code;
    void'($urandom(32'd24680));
    rst_n = 1'b0; wr_n = 1'b1; cs_n = 1'b1; sclk = 1'b0; sdata = 1'b0;
    load = 1'b0; tc = 4'd0; fsel_in = 1'b0; sleep_in = 1'b0; data_in = '0;
    m_par = '0; m_ser = '0; m_f0 = '0; m_f1 = '0; m_ph = '0; m_iq = '0; m_ctl = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R9 reset");

    // R2: 8-bit load with junk on the upper lines
    par_word(32'hA1B2C3D4);
    xfer(4'b1000);
    chk("R2 8-bit freq0", freq0, 32'hA1B2C3D4);
    // R10: deselected write leaves the staging word alone
    par_wr(16'h5A5A, 1'b0);
    xfer(4'b1001);
    chk("R10 cs high freq1", freq1, 32'hA1B2C3D4);
    // R1: 16-bit mode
    set_ctl(4'b0001);
    chk("R6 bus16", {31'd0, bus16}, 32'd1);
    par_word(32'h12345678);
    xfer(4'b1010);
    chk("R5 phase low 12", {20'd0, phase_ofs}, 32'h678);
    xfer(4'b1011);
    chk("R5 iq low 20", {12'd0, iq_amp}, 32'h45678);
    // R3: serial
    ser_word(32'h8000_0001);
    xfer(4'b1100);
    chk("R3 serial freq0", freq0, 32'h8000_0001);
    ser_word(32'hDEADBEEF);
    xfer(4'b1101);
    chk("R3 serial freq1", freq1, 32'hDEADBEEF);
    xfer(4'b1110);
    xfer(4'b1111);
    chk_all("R4 serial dests");
    // R4: unused codes change nothing
    xfer(4'b0101);
    xfer(4'b0110);
    chk_all("R4 01xx no effect");
    // R6: external sleep and control bits
    sleep_in = 1'b1;
    #1 chk("R6 sleep_in", {31'd0, sleep_out}, 32'd1);
    sleep_in = 1'b0;
    set_ctl(4'b0111);
    chk_all("R6 control bits");

    // R7: staging word changes while load held high
    par_word(32'hCAFE0001);
    @(negedge clk); tc = 4'b1000; load = 1'b1;
    repeat (6) @(negedge clk);
    model_xfer(4'b1000);
    old = m_f0;
    par_word(32'h0BADF00D);
    repeat (6) @(negedge clk);
    chk("R7 held load", freq0, old);
    load = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 after release", freq0, old);

    // R8: bypass latency
    set_ctl(4'b1001);
    chk("R8 bypass on", {31'd0, sync_off}, 32'd1);
    par_word(32'h11112222);
    @(negedge clk); tc = 4'b1000; load = 1'b1; fsel_in = 1'b1;
    #1 chk("R8 bypass fsel", {31'd0, fsel_out}, 32'd1);
    @(negedge clk);
    chk("R8 bypass lands first edge", freq0, 32'h11112222);
    model_xfer(4'b1000);
    repeat (3) @(negedge clk);
    load = 1'b0; fsel_in = 1'b0;
    repeat (6) @(negedge clk);
    // R8: synchronised latency
    set_ctl(4'b0001);
    par_word(32'h33334444);
    @(negedge clk); tc = 4'b1000; load = 1'b1; fsel_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 sync fsel early", {31'd0, fsel_out}, 32'd0);
    @(negedge clk);
    chk("R8 sync fsel 4 late", {31'd0, fsel_out}, 32'd1);
    chk("R8 sync not yet", freq0, 32'h11112222);
    @(negedge clk);
    chk("R8 sync lands", freq0, 32'h33334444);
    model_xfer(4'b1000);
    repeat (3) @(negedge clk);
    load = 1'b0; fsel_in = 1'b0;
    repeat (8) @(negedge clk);

    // random mix across R1 R2 R3 R4 R5
    for (int n = 0; n < 40; n++) begin
      if (n % 8 == 0) set_ctl({1'($urandom), 2'b00, 1'($urandom)});
      v = $urandom;
      code = 4'($urandom);
      if (code[3] == 1'b0) code = 4'b1000 | {2'b00, code[1:0]};
      if (code[2]) ser_word(v); else par_word(v);
      xfer(code);
      chk_all("R4 random transfer");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule